// File: doc/BRIEF.md
# Program/Erase Suspend-Resume Sequencer

This block stands in for the timing engine of a serial NOR flash while a page program or an erase is running. A decoded opcode byte with a valid strobe starts an operation, whose length is modelled by a down-counter. A suspend opcode freezes the remaining time and, after an entry delay, places the engine in a suspended state. A resume opcode continues the count from the point where it stopped. Three status flags come out of the block: operation in progress, suspended, and last-operation-failed.

All durations are given in microseconds or milliseconds and turned into clock ticks through two rate parameters, so one design serves any clock rate. The block does not hold array contents, serialise bits or check block protection. It only decides when an operation is busy, paused, finished or aborted. A fault input stands for an internal program or erase failure and ends the operation at once.

Top module: `sr_seq`

## Requirements
- R1: A strobed opcode 02h starts a program; 81h, 20h, 52h, D8h, 60h and C7h start an erase. Any other opcode except the suspend and resume codes is ignored, and wip and sus stay 0.
- R2: From idle, wip (`wip`=1 means busy) rises after the command's clock edge. It stays high for exactly PROG_MS*TICKS_PER_MS cycles for a program and ERASE_MS*TICKS_PER_MS cycles for any erase, then falls.
- R3: While an operation runs or is suspended, further program or erase opcodes are rejected and leave the remaining time unchanged.
- R4: A suspend (75h or B0h) accepted while running keeps wip=1 and sus=0 for exactly SUS_ENTRY_US*TICKS_PER_US cycles, and then gives sus=1 and wip=0. The entry phase never lasts SUS_MAX_US*TICKS_PER_US cycles or more.
- R5: A resume (7Ah or 30h) while suspended gives wip=1 and sus=0 from the next cycle. A suspend arriving before RES_GAP_US*TICKS_PER_US running cycles have elapsed since that resume is dropped and is not deferred.
- R6: While suspended, the remaining operation time is held. After resume, wip stays high for exactly the cycles that were left when the suspend was accepted.
- R7: A suspend with no operation running, and a resume when not suspended, have no effect.
- R8: A fault pulse while running, entering suspend or suspended aborts the operation: wip=0, sus=0 and ep_fail=1 on the next cycle. A fault while idle changes nothing.
- R9: ep_fail clears on the clock edge that starts the next program or erase.
- R10: After reset, wip, sus and ep_fail are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Opcode strobe, one cycle per command |
| cmd_code | input | 8 | Opcode byte sampled with cmd_valid |
| fault | input | 1 | Abort request for the current operation |
| wip | output | 1 | Operation in progress |
| sus | output | 1 | Operation suspended |
| ep_fail | output | 1 | Last program or erase was aborted |

## Verification
A corrupted remaining-time counter shows as a wip pulse of the wrong length, which is visible only when the operation ends, up to one full erase later. The bench therefore measures every busy window to the exact cycle. A wrong entry or gap counter shows within a few tens of cycles: sus rises too early or too late, or a suspend that should be dropped is taken. The gap sweep places suspends on both sides of the boundary to catch off-by-one errors. A state stuck in pause or abort shows at once as wip and sus disagreeing with the command just sent.

// File: rtl/sr_seq_pkg.sv
package sr_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PEND = 2'd2,
    ST_SUSP = 2'd3
  } sr_state_e;

  // microseconds to clock ticks
  function automatic int unsigned us_ticks(input int unsigned us, input int unsigned per_us);
    return us * per_us;
  endfunction

  // milliseconds to clock ticks
  function automatic int unsigned ms_ticks(input int unsigned ms, input int unsigned per_ms);
    return ms * per_ms;
  endfunction

  // bits needed to hold 0..v, never less than one
  function automatic int unsigned cnt_bits(input int unsigned v);
    return (v < 2) ? 1 : $clog2(v + 1);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sr_cmd_decode.sv
module sr_cmd_decode (
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  output logic       go_prog,
  output logic       go_erase,
  output logic       sus_req,
  output logic       res_req
);

  always_comb begin
    go_prog  = 1'b0;
    go_erase = 1'b0;
    sus_req  = 1'b0;
    res_req  = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_code)
        8'h02:                                    go_prog  = 1'b1;
        8'h81, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7: go_erase = 1'b1;
        8'h75, 8'hB0:                             sus_req  = 1'b1;
        8'h7A, 8'h30:                             res_req  = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sr_down_timer.sv
module sr_down_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      count <= '0;
    else if (load)                   count <= load_val;
    else if (dec && count != '0)     count <= count - W'(1);
  end

endmodule

// File: rtl/sr_seq.sv
module sr_seq
  import sr_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_US = 100,
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned PROG_MS      = 2,
  parameter int unsigned ERASE_MS     = 16,
  parameter int unsigned SUS_ENTRY_US = 20,
  parameter int unsigned SUS_MAX_US   = 30,
  parameter int unsigned RES_GAP_US   = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_code,
  input  logic       fault,
  output logic       wip,
  output logic       sus,
  output logic       ep_fail
);

  localparam int unsigned PROG_TICKS  = ms_ticks(PROG_MS, TICKS_PER_MS);
  localparam int unsigned ERASE_TICKS = ms_ticks(ERASE_MS, TICKS_PER_MS);
  localparam int unsigned ENTRY_TICKS = us_ticks(SUS_ENTRY_US, TICKS_PER_US);
  localparam int unsigned MAX_TICKS   = us_ticks(SUS_MAX_US, TICKS_PER_US);
  localparam int unsigned GAP_TICKS   = us_ticks(RES_GAP_US, TICKS_PER_US);
  localparam int unsigned DW = cnt_bits(max2(PROG_TICKS, ERASE_TICKS));
  localparam int unsigned LW = cnt_bits(ENTRY_TICKS);
  localparam int unsigned GW = cnt_bits(GAP_TICKS);
  localparam int unsigned PW = cnt_bits(MAX_TICKS);

  // decoded command events
  logic go_prog, go_erase, sus_req, res_req;

  sr_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .go_prog   (go_prog),
    .go_erase  (go_erase),
    .sus_req   (sus_req),
    .res_req   (res_req)
  );

  sr_state_e state, state_nx;
  logic [DW-1:0] rem_cnt;
  logic [LW-1:0] lat_cnt;
  logic [GW-1:0] gap_cnt;

  // named internal events
  logic start_go, fault_hit, sus_take, res_take, run_tick, lat_tick, op_done, pend_done, gap_open;

  assign gap_open  = (gap_cnt == '0);
  assign start_go  = (state == ST_IDLE) && (go_prog || go_erase);
  assign fault_hit = fault && (state != ST_IDLE);
  assign sus_take  = (state == ST_RUN) && sus_req && gap_open && !fault_hit;
  assign res_take  = (state == ST_SUSP) && res_req && !fault_hit;
  assign run_tick  = (state == ST_RUN) && !sus_take && !fault_hit;
  assign op_done   = run_tick && (rem_cnt == DW'(1));
  assign lat_tick  = (state == ST_PEND) && !fault_hit;
  assign pend_done = lat_tick && (lat_cnt == LW'(1));

  // remaining operation time
  sr_down_timer #(.W(DW)) u_rem (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go),
    .load_val (go_prog ? DW'(PROG_TICKS) : DW'(ERASE_TICKS)),
    .dec      (run_tick),
    .count    (rem_cnt)
  );

  // suspend entry latency
  sr_down_timer #(.W(LW)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sus_take),
    .load_val (LW'(ENTRY_TICKS)),
    .dec      (lat_tick),
    .count    (lat_cnt)
  );

  // minimum running time after resume before suspend is honoured
  sr_down_timer #(.W(GW)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start_go || res_take),
    .load_val (res_take ? GW'(GAP_TICKS) : '0),
    .dec      (run_tick),
    .count    (gap_cnt)
  );

  always_comb begin
    state_nx = state;
    if (fault_hit) state_nx = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: if (start_go) state_nx = ST_RUN;
        ST_RUN:  if (sus_take) state_nx = ST_PEND;
                 else if (op_done) state_nx = ST_IDLE;
        ST_PEND: if (pend_done) state_nx = ST_SUSP;
        ST_SUSP: if (res_take) state_nx = ST_RUN;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ep_fail <= 1'b0;
    else if (fault_hit) ep_fail <= 1'b1;
    else if (start_go)  ep_fail <= 1'b0;
  end

  assign wip = (state == ST_RUN) || (state == ST_PEND);
  assign sus = (state == ST_SUSP);

  // ---------------- checking logic ----------------
  logic [PW-1:0] pend_age;
  logic [GW-1:0] run_since_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_age <= '0;
    else if (sus_take) pend_age <= '0;
    else if (state == ST_PEND && pend_age != PW'(MAX_TICKS)) pend_age <= pend_age + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_since_res <= GW'(GAP_TICKS);
    else if (start_go) run_since_res <= GW'(GAP_TICKS);
    else if (res_take) run_since_res <= '0;
    else if (run_tick && run_since_res != GW'(GAP_TICKS)) run_since_res <= run_since_res + GW'(1);
  end

  assert_entry_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PEND) |-> (pend_age < PW'(MAX_TICKS)));

  assert_resume_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sus_take |-> (run_since_res >= GW'(GAP_TICKS)));

  assert_time_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |=> $stable(rem_cnt));

  assert_fail_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ep_fail) |-> $past(fault));

  assert_fail_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !ep_fail);

  assert_exclusive_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus) |-> $past(state == ST_PEND));

endmodule

// File: tb/sim_sr_seq.sv
`timescale 1ns/1ps
module sim_sr_seq;
  localparam int TPU = 2, TPM = 20, PMS = 2, EMS = 16, ENT = 5, MAXU = 30, GAPU = 20;
  localparam int PT = PMS * TPM;
  localparam int ET = EMS * TPM;
  localparam int LT = ENT * TPU;
  localparam int GT = GAPU * TPU;

  logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, fault = 1'b0;
  logic [7:0] cmd_code = 8'h00;
  logic wip, sus, ep_fail;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sr_seq #(.TICKS_PER_US(TPU), .TICKS_PER_MS(TPM), .PROG_MS(PMS), .ERASE_MS(EMS),
           .SUS_ENTRY_US(ENT), .SUS_MAX_US(MAXU), .RES_GAP_US(GAPU)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .fault(fault), .wip(wip), .sus(sus), .ep_fail(ep_fail));

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (wip === 1'b1 && n < 5000) begin n++; @(negedge clk); end
  endtask

  task automatic until_sus(output int n);
    n = 0;
    while (sus !== 1'b1 && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_fault();
    fault = 1'b1; @(negedge clk); fault = 1'b0;
  endtask

  function automatic bit starts_op(input int c);
    return c == 8'h02 || c == 8'h81 || c == 8'h20 || c == 8'h52 ||
           c == 8'hD8 || c == 8'h60 || c == 8'hC7;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] erase_codes [6] = '{8'h81, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7};
    int gaps [6] = '{0, 20, GT-2, GT-1, GT, GT+1};

    wait_n(3);
    chk("R10 reset wip", wip, 0);
    chk("R10 reset sus", sus, 0);
    chk("R10 reset ep_fail", ep_fail, 0);
    rst_n = 1'b1;
    wait_n(1);

    // R1 R2 program and every erase code
    send(8'h02); busy_len(n); chk("R1 R2 program length", n, PT);
    foreach (erase_codes[k]) begin
      send(erase_codes[k]); busy_len(n);
      chk($sformatf("R1 R2 erase %02h length", erase_codes[k]), n, ET);
    end

    // R1 R7 all other opcodes from idle
    for (int c = 0; c < 256; c++) begin
      if (!starts_op(c)) begin
        send(8'(c));
        chk($sformatf("R1 R7 code %02h wip", c), wip, 0);
        chk($sformatf("R1 R7 code %02h sus", c), sus, 0);
      end
    end

    // R3 R7 commands during a running program do not change its length
    send(8'h02);
    begin
      int i = 0; n = 0;
      while (wip === 1'b1 && i < 1000) begin
        n++;
        cmd_valid = (i == 3 || i == 6 || i == 9 || i == 12);
        cmd_code  = (i == 3) ? 8'h7A : (i == 6) ? 8'hD8 : (i == 9) ? 8'h30 : 8'h02;
        i++;
        @(negedge clk);
      end
      cmd_valid = 1'b0;
    end
    chk("R3 R7 run length with stray commands", n, PT);

    // R4 entry latency, R6 hold, R3 rejection while suspended, R5 resume
    send(8'h20); wait_n(5); send(8'h75);
    chk("R4 entering wip", wip, 1);
    chk("R4 entering sus", sus, 0);
    until_sus(n);
    chk("R4 entry cycles", n, LT);
    chk("R4 entry under maximum", int'(LT < MAXU * TPU), 1);
    chk("R4 suspended wip", wip, 0);
    wait_n(60);
    chk("R6 still suspended", sus, 1);
    send(8'h20); chk("R3 erase rejected sus", sus, 1); chk("R3 erase rejected wip", wip, 0);
    send(8'h02); chk("R3 program rejected sus", sus, 1); chk("R3 program rejected wip", wip, 0);
    send(8'h7A);
    chk("R5 resume wip", wip, 1);
    chk("R5 resume sus", sus, 0);
    busy_len(n);
    chk("R6 remaining after resume", n, ET - 5);

    // R5 gap sweep around the boundary
    foreach (gaps[k]) begin
      send(8'h52); send(8'hB0); until_sus(n);
      send(8'h30); wait_n(gaps[k]); send(8'h75); wait_n(LT);
      chk($sformatf("R5 suspend after %0d run cycles", gaps[k]), sus, int'(gaps[k] >= GT));
      if (sus === 1'b1) send(8'h7A);
      busy_len(n);
    end

    // R8 R9 fault behaviour
    send(8'hD8); wait_n(7); pulse_fault();
    chk("R8 abort wip", wip, 0);
    chk("R8 abort sus", sus, 0);
    chk("R8 abort ep_fail", ep_fail, 1);
    pulse_fault();
    chk("R8 idle fault ep_fail", ep_fail, 1);
    chk("R8 idle fault wip", wip, 0);
    send(8'h02);
    chk("R9 start clears ep_fail", ep_fail, 0);
    busy_len(n);
    chk("R9 program after fault length", n, PT);

    send(8'h60); send(8'h75); until_sus(n); pulse_fault();
    chk("R8 suspended abort sus", sus, 0);
    chk("R8 suspended abort ep_fail", ep_fail, 1);
    send(8'h7A);
    chk("R7 resume after abort wip", wip, 0);
    send(8'hC7);
    chk("R9 erase clears ep_fail", ep_fail, 0);
    busy_len(n);
    chk("R9 erase after fault length", n, ET);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule